// File: doc/BRIEF.md
# Burst Offset Sequencer

This block produces the low-order word offset for a synchronous burst memory. A start strobe captures the low bits of an external address and clears an internal beat counter. Each qualified advance then steps the counter by one beat. The offset on the output is formed from the captured start value and the counter. A run-time order input selects between two forms. In interleaved order the offset is the start value XOR the counter. In linear order it is the start value plus the counter, wrapping modulo the burst length. The caller joins the offset with the upper address bits it holds in its own register.

Two strobes can start a burst. The processor strobe always opens a read burst, whatever the write input shows. The controller strobe takes effect only while the processor strobe is idle, and it samples the write input to choose between a read burst and a write burst. An advance that arrives on a start edge is ignored. On later edges an advance moves the counter only if the write input matches the direction of the burst. This makes the read-side and write-side step conditions one rule. The sequencing is held in a three-state machine. `S_IDLE` is the state after reset, and no burst is open. `S_RD` is an open read burst and `S_WR` is an open write burst. The transitions are: `T_PROC_LOAD` from any state to `S_RD` on the processor strobe. `T_CTRL_RD` from any state to `S_RD` on the controller strobe with write low. `T_CTRL_WR` from any state to `S_WR` on the controller strobe with write high. With no strobe the machine holds its state (`T_HOLD`).

Top module: `burst_ofs_gen`

## Requirements
- R1: After reset the offset is 0 and the machine is in `S_IDLE`. Advance pulses have no effect until a strobe starts a burst.
- R2: On an edge where `proc_ld` is high, `start_ofs` is captured and the beat count returns to 0. After that edge the offset equals the captured start. An `adv` pulse on that same edge is ignored.
- R3: On an edge where `ctrl_ld` is high and `proc_ld` is low, `start_ofs` is captured and the beat count is cleared. The burst becomes a write burst if `wr` is 1 and a read burst if `wr` is 0.
- R4: In a read burst, an edge with `adv`=1, `wr`=0 and both strobes low advances the count by one. An edge with `adv`=0 leaves the offset unchanged.
- R5: In a write burst, an edge with `adv`=1 and `wr`=1 advances the count. A write burst does not move when `wr`=0, and a read burst does not move when `wr`=1.
- R6: With `order_intl`=1 the offset is `start XOR count`. For example, start 1 gives 1,0,3,2 and start 2 gives 2,3,0,1.
- R7: With `order_intl`=0 the offset is `(start + count) mod 4`. For example, start 1 gives 1,2,3,0 and start 3 gives 3,0,1,2.
- R8: After four advances the count wraps to 0, so the offset returns to the start value. Further advances continue the same cycle.
- R9: If both strobes are high on one edge, the processor strobe wins and a read burst opens regardless of `wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| proc_ld | input | 1 | Processor start strobe, active high, always opens a read burst |
| ctrl_ld | input | 1 | Controller start strobe, active high, direction taken from `wr` |
| start_ofs | input | OFS_W | Low address bits captured on a start |
| adv | input | 1 | Burst advance request, active high |
| wr | input | 1 | Write indication, high while a write or byte write is requested |
| order_intl | input | 1 | 1 selects interleaved order, 0 selects linear order |
| burst_ofs | output | OFS_W | Current burst offset |

## Verification
The bench builds the block with its default `OFS_W` of 2, which gives a four-beat burst. With that width, every start value and both orders can be walked through a complete wrap in a few cycles. This puts the XOR pattern and the modulo-4 pattern side by side for the same start values. It also makes the wrap at the fifth beat directly observable. Strobes are applied mid-burst and on edges where an advance is also present. These cases exercise the count clearing, the priority between the strobes, and the gating of advance by burst direction.

// File: rtl/bog_pkg.sv
`timescale 1ns/1ps
package bog_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RD   = 2'd1,
        S_WR   = 2'd2
    } bog_state_t;
endpackage

// File: rtl/bog_fsm.sv
`timescale 1ns/1ps
module bog_fsm
    import bog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       proc_ld,
    input  logic       ctrl_ld,
    input  logic       adv,
    input  logic       wr,
    output bog_state_t state,
    output logic       load,
    output logic       step
);
    bog_state_t state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d = state;
        load    = proc_ld || ctrl_ld;
        step    = 1'b0;
        if (proc_ld) begin
            state_d = S_RD;                    // T_PROC_LOAD
        end else if (ctrl_ld) begin
            state_d = wr ? S_WR : S_RD;        // T_CTRL_WR / T_CTRL_RD
        end else begin
            unique case (state)                // T_HOLD
                S_IDLE:  step = 1'b0;
                S_RD:    step = adv && !wr;
                S_WR:    step = adv && wr;
                default: step = 1'b0;
            endcase
        end
    end

    // R9: the processor strobe always opens a read burst
    assert_proc_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        proc_ld |=> state == S_RD);

    // R3: controller strobe direction follows wr
    assert_ctrl_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_ld && !proc_ld) |=> state == ($past(wr) ? S_WR : S_RD));

    // R1: no step while idle
    assert_idle_nostep_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> !step);
endmodule

// File: rtl/bog_seq.sv
`timescale 1ns/1ps
module bog_seq #(
    parameter int OFS_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [OFS_W-1:0] start,
    input  logic             intl,
    output logic [OFS_W-1:0] ofs
);
    localparam logic [OFS_W-1:0] CNT_LAST = {OFS_W{1'b1}};

    logic [OFS_W-1:0] cnt_q;
    logic [OFS_W-1:0] start_q;
    logic [OFS_W-1:0] ofs_xor;
    logic [OFS_W-1:0] ofs_lin;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            start_q <= '0;
        end else if (load) begin
            cnt_q   <= '0;
            start_q <= start;
        end else if (step) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    // interleaved order: bitwise XOR of start and beat count
    for (genvar b = 0; b < OFS_W; b++) begin : g_xor
        assign ofs_xor[b] = start_q[b] ^ cnt_q[b];
    end

    // linear order: sum wraps naturally at the offset width
    assign ofs_lin = start_q + cnt_q;
    assign ofs     = intl ? ofs_xor : ofs_lin;

    // R4: count holds without a step or load
    assert_cnt_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(cnt_q));

    // R8: a step from the last beat returns to the first
    assert_cnt_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && step && cnt_q == CNT_LAST) |=> cnt_q == '0);
endmodule

// File: rtl/burst_ofs_gen.sv
`timescale 1ns/1ps
module burst_ofs_gen
    import bog_pkg::*;
#(
    parameter int OFS_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             proc_ld,
    input  logic             ctrl_ld,
    input  logic [OFS_W-1:0] start_ofs,
    input  logic             adv,
    input  logic             wr,
    input  logic             order_intl,
    output logic [OFS_W-1:0] burst_ofs
);
    bog_state_t state;
    logic       load;
    logic       step;

    bog_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .proc_ld (proc_ld),
        .ctrl_ld (ctrl_ld),
        .adv     (adv),
        .wr      (wr),
        .state   (state),
        .load    (load),
        .step    (step)
    );

    bog_seq #(.OFS_W(OFS_W)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .step  (step),
        .start (start_ofs),
        .intl  (order_intl),
        .ofs   (burst_ofs)
    );

    // R2: after a processor start the offset equals the captured start
    assert_proc_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        proc_ld |=> burst_ofs == $past(start_ofs));

    // R1: idle means offset zero in either order
    assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> burst_ofs == '0);

    // R5: a read burst with wr high does not move
    assert_rd_wr_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RD && wr && !proc_ld && !ctrl_ld) |=> !$past(step));
endmodule

// File: tb/test_burst_ofs_gen.sv
`timescale 1ns/1ps
module test_burst_ofs_gen;
    localparam int OFS_W = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             proc_ld = 1'b0;
    logic             ctrl_ld = 1'b0;
    logic [OFS_W-1:0] start_ofs = '0;
    logic             adv = 1'b0;
    logic             wr = 1'b0;
    logic             order_intl = 1'b1;
    logic [OFS_W-1:0] burst_ofs;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    burst_ofs_gen #(.OFS_W(OFS_W)) i_burst_ofs_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .proc_ld    (proc_ld),
        .ctrl_ld    (ctrl_ld),
        .start_ofs  (start_ofs),
        .adv        (adv),
        .wr         (wr),
        .order_intl (order_intl),
        .burst_ofs  (burst_ofs)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [OFS_W-1:0] exp);
        n_checks++;
        if (burst_ofs !== exp) begin
            n_fail++;
            $display("FAIL %s: burst_ofs=%0d expected %0d", req, burst_ofs, exp);
        end
    endtask

    task automatic quiet();
        proc_ld = 0; ctrl_ld = 0; adv = 0; wr = 0;
    endtask

    // R1: reset state, advance has no effect while idle
    task automatic t_reset();
        quiet();
        rst_n = 0; tick(); tick();
        rst_n = 1; tick();
        chk("R1 reset", 2'd0);
        adv = 1; tick(); tick();
        chk("R1 idle adv", 2'd0);
        quiet();
    endtask

    // R2 R4 R6 R8: interleaved read burst with adv on the load edge
    task automatic t_intl_read(input logic [1:0] s);
        order_intl = 1;
        proc_ld = 1; start_ofs = s; adv = 1; wr = 1;
        tick();
        chk("R2 load ignores adv", s);
        proc_ld = 0; wr = 0; adv = 1;
        for (int k = 1; k <= 6; k++) begin
            tick();
            chk((k >= 4) ? "R8 intl wrap" : "R6 intl", s ^ 2'(k));
        end
        quiet();
    endtask

    // R7 R8: linear read burst through the controller strobe
    task automatic t_lin_read(input logic [1:0] s);
        order_intl = 0;
        ctrl_ld = 1; wr = 0; start_ofs = s;
        tick();
        chk("R3 ctrl load", s);
        ctrl_ld = 0; adv = 1;
        for (int k = 1; k <= 5; k++) begin
            tick();
            chk((k >= 4) ? "R8 lin wrap" : "R7 lin", 2'(s + k));
        end
        quiet();
        order_intl = 1;
    endtask

    // R4: advance low holds the offset
    task automatic t_hold();
        order_intl = 0;
        proc_ld = 1; start_ofs = 2'd2; tick(); proc_ld = 0;
        adv = 1; tick();
        chk("R4 step", 2'd3);
        adv = 0; tick(); tick();
        chk("R4 hold", 2'd3);
        quiet(); order_intl = 1;
    endtask

    // R3 R5: write burst direction gating
    task automatic t_write();
        order_intl = 1;
        ctrl_ld = 1; wr = 1; start_ofs = 2'd1; tick();
        chk("R3 ctrl write load", 2'd1);
        ctrl_ld = 0; adv = 1; wr = 1; tick();
        chk("R5 write step", 2'd0);
        wr = 0; tick();
        chk("R5 write blocked wr=0", 2'd0);
        wr = 1; tick();
        chk("R5 write step again", 2'd3);
        quiet();
    endtask

    // R5: read burst does not move with wr high
    task automatic t_read_block();
        order_intl = 1;
        proc_ld = 1; start_ofs = 2'd3; tick(); proc_ld = 0;
        adv = 1; wr = 1; tick();
        chk("R5 read blocked wr=1", 2'd3);
        wr = 0; tick();
        chk("R5 read step", 2'd2);
        quiet();
    endtask

    // R9: both strobes, processor wins and opens a read burst
    task automatic t_priority();
        order_intl = 0;
        proc_ld = 1; ctrl_ld = 1; wr = 1; start_ofs = 2'd2; tick();
        chk("R9 both strobes load", 2'd2);
        proc_ld = 0; ctrl_ld = 0; adv = 1; wr = 1; tick();
        chk("R9 read burst ignores wr=1", 2'd2);
        wr = 0; tick();
        chk("R9 read burst steps", 2'd3);
        quiet(); order_intl = 1;
    endtask

    // R2: reload mid burst clears the count
    task automatic t_reload();
        order_intl = 1;
        proc_ld = 1; start_ofs = 2'd0; tick(); proc_ld = 0;
        adv = 1; tick(); tick();
        chk("R6 mid burst", 2'd2);
        proc_ld = 1; start_ofs = 2'd1; tick(); proc_ld = 0;
        chk("R2 reload", 2'd1);
        tick();
        chk("R2 count cleared", 2'd0);
        quiet();
    endtask

    initial begin
        t_reset();
        t_intl_read(2'd1);
        t_intl_read(2'd2);
        t_lin_read(2'd1);
        t_lin_read(2'd3);
        t_hold();
        t_write();
        t_read_block();
        t_priority();
        t_reload();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule